// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Fractional Clock Divider

This block turns a stream of sample values into a pulse-width-modulated pin. A free-running up-counter advances once per divided clock tick. It runs from zero to a programmable upper limit and then starts over at zero. The output pin is high while the counter is below the active compare value. Each value written to the compare register therefore sets the duty cycle of the following periods, and a steady stream of such writes produces an audio waveform after a low-pass filter.

The divided tick comes from a phase accumulator. The divider value is expressed in sixteenths of a system clock, so ratios such as 1.5 or 2.25 are possible. The tick rate averages out exactly over time. A compare write first lands in a shadow register. It reaches the comparator only when the counter wraps, so a write in the middle of a period never cuts a pulse short or adds an extra one.

A small control finite-state machine sets whether the slice runs. It has two states:
- HALT: the counter is frozen, the pin is low, the divider phase is cleared, and the active compare follows the shadow.
- RUN: ticks advance the counter, and wraps reload the compare.

The machine moves from HALT to RUN when the enable bit is set. It moves from RUN to HALT when the enable bit is cleared.

Top module: `pwm_slice`

## Requirements
- R1: Bit 0 of the control register (address 0) enables the slice. While it is clear, the pin is low and the counter keeps its value. When the bit is set again, counting resumes from that held value rather than from zero.
- R2: The divider register (address 1) holds an integer part in bits 11:4 and a fraction in bits 3:0. The counter advances once per value/16 system clocks, so 0x010 advances it every cycle and 0x030 every third cycle.
- R3: A divider value of 0 divides by 256. A divider value from 1 to 15 (integer part zero) divides by 1.
- R4: A fractional divider spreads the ticks evenly, and the long-run rate is exactly 16/value. For example, 0x018 gives 2 ticks every 3 cycles. For any divider of 2 or more, two ticks never fall in adjacent cycles.
- R5: The counter runs from 0 to TOP (address 3) inclusive, so one period is TOP+1 ticks. If TOP is lowered below the present count, the counter returns to 0 on the next tick.
- R6: The pin is high while the counter is below the active compare value. The resulting cases are:
  - a compare of 0 gives a constant low;
  - a compare greater than TOP gives a constant high;
  - a compare equal to TOP gives TOP high ticks out of TOP+1.
- R7: A compare write (address 2) goes to a shadow register. The shadow is copied to the active compare only when the counter wraps from TOP to 0, or at any time while the slice is halted.
- R8: The compare and TOP registers keep only bits 15:0 of a write, the divider keeps bits 11:0 and the control register keeps bit 0. A read returns the kept bits and zeros elsewhere. The compare address reads back the shadow.
- R9: After reset, the registers hold these values and the pin is low:
  - control: 0;
  - divider: 0x010;
  - compare: 0;
  - TOP: 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Register select: 0 control, 1 divider, 2 compare, 3 TOP |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, available in the same cycle |
| pwm_out | output | 1 | Modulated output pin |

## Verification
Read data is combinational, so readback is sampled in the same cycle the address is presented. A write takes effect at the next rising edge. The control state follows one edge after that, and a new compare reaches the pin one tick after the next wrap. Because of this sequence, the duty-cycle and rate checks do not look for a particular edge. Each check first waits longer than one full period. It then counts high samples and rising edges over a window that is a whole multiple of the period, so the result does not depend on where the window starts. The hold and no-glitch checks synchronise on a falling edge of the pin. They then sample only in windows kept a safe number of ticks away from the next wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } slice_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_CMP  = 2'd2;
    localparam logic [1:0] ADDR_TOP  = 2'd3;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DIV_INT_W  = 8,
    parameter int DIV_FRAC_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [1:0]                      addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    output logic                            enable,
    output logic [DIV_INT_W+DIV_FRAC_W-1:0] div_val,
    output logic [CNT_W-1:0]                cmp_shadow,
    output logic [CNT_W-1:0]                top_val
);
    localparam int DIV_W = DIV_INT_W + DIV_FRAC_W;
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1) << DIV_FRAC_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable     <= 1'b0;
            div_val    <= DIV_ONE;
            cmp_shadow <= '0;
            top_val    <= '1;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_CTRL: enable     <= wdata[0];
                ADDR_DIV:  div_val    <= wdata[DIV_W-1:0];
                ADDR_CMP:  cmp_shadow <= wdata[CNT_W-1:0];
                ADDR_TOP:  top_val    <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: rdata[0]         = enable;
            ADDR_DIV:  rdata[DIV_W-1:0] = div_val;
            ADDR_CMP:  rdata[CNT_W-1:0] = cmp_shadow;
            ADDR_TOP:  rdata[CNT_W-1:0] = top_val;
            default: ;
        endcase
    end

endmodule

// File: rtl/pwm_clkdiv.sv
module pwm_clkdiv #(
    parameter int DIV_INT_W  = 8,
    parameter int DIV_FRAC_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run,
    input  logic [DIV_INT_W+DIV_FRAC_W-1:0] div_val,
    output logic                            tick
);
    localparam int DIV_W = DIV_INT_W + DIV_FRAC_W;
    localparam int ACC_W = DIV_W + 1;
    localparam logic [ACC_W-1:0] STEP    = ACC_W'(1) << DIV_FRAC_W;
    localparam logic [ACC_W-1:0] DIV_MAX = ACC_W'(1) << DIV_W;

    logic [ACC_W-1:0] eff;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W:0]   sum;

    // Effective divisor in sixteenths: zero selects the largest ratio,
    // anything under one whole clock is raised to one.
    always_comb begin
        if (div_val == '0) begin
            eff = DIV_MAX;
        end else if ({1'b0, div_val} < STEP) begin
            eff = STEP;
        end else begin
            eff = {1'b0, div_val};
        end
    end

    assign sum  = {1'b0, acc_q} + {1'b0, STEP};
    assign tick = run && (sum >= {1'b0, eff});

    always_comb begin
        if (!run) begin
            acc_d = '0;
        end else if (acc_q >= eff) begin
            acc_d = '0;
        end else if (tick) begin
            acc_d = ACC_W'(sum - {1'b0, eff});
        end else begin
            acc_d = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R4: with a ratio of two or more, a tick is never followed by another
    p_no_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eff >= (STEP << 1)) |=> (!tick || eff != $past(eff)));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_val,
    input  logic [CNT_W-1:0] cmp_shadow,
    output logic             run,
    output logic             pwm_out
);
    slice_state_t     state_q;
    slice_state_t     state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] cmp_d;
    logic             wrap_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (enable)  state_d = ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_HALT;
        endcase
    end

    assign wrap_hit = (cnt_q >= top_val);

    always_comb begin
        cnt_d = cnt_q;
        cmp_d = cmp_act;
        unique case (state_q)
            ST_HALT: cmp_d = cmp_shadow;
            ST_RUN: begin
                if (tick) begin
                    if (wrap_hit) begin
                        cnt_d = '0;
                        cmp_d = cmp_shadow;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cmp_act <= '0;
        end else begin
            cnt_q   <= cnt_d;
            cmp_act <= cmp_d;
        end
    end

    assign run     = (state_q == ST_RUN);
    assign pwm_out = run && (cnt_q < cmp_act);

    // R1: a halted slice never moves its counter
    p_halt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> $stable(cnt_q));

    // R5: a tick at or past TOP returns the count to zero
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q >= top_val) |=> (cnt_q == '0));

    // R5: a tick below TOP steps the count by one
    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q < top_val) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R7: while running, the active compare only changes at a wrap
    p_cmp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !(tick && cnt_q >= top_val)) |=> $stable(cmp_act));

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
    import pwm_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DIV_INT_W  = 8,
    parameter int DIV_FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    localparam int DIV_W = DIV_INT_W + DIV_FRAC_W;

    logic             enable;
    logic [DIV_W-1:0] div_val;
    logic [CNT_W-1:0] cmp_shadow;
    logic [CNT_W-1:0] top_val;
    logic             run;
    logic             tick;

    pwm_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W),
        .DIV_INT_W(DIV_INT_W), .DIV_FRAC_W(DIV_FRAC_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .enable(enable),
        .div_val(div_val), .cmp_shadow(cmp_shadow), .top_val(top_val)
    );

    pwm_clkdiv #(
        .DIV_INT_W(DIV_INT_W), .DIV_FRAC_W(DIV_FRAC_W)
    ) i_clkdiv (
        .clk(clk), .rst_n(rst_n), .run(run), .div_val(div_val), .tick(tick)
    );

    pwm_counter #(
        .CNT_W(CNT_W)
    ) i_counter (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .top_val(top_val), .cmp_shadow(cmp_shadow), .run(run), .pwm_out(pwm_out)
    );

endmodule

// File: tb/test_pwm_slice.sv
module test_pwm_slice;

    localparam time CLK_PERIOD = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_slice i_pwm_slice (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic measure(input int n, output int hi, output int rises);
        logic p;
        hi = 0; rises = 0;
        @(negedge clk);
        p = pwm_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (pwm_out && !p) rises++;
            p = pwm_out;
        end
    endtask

    task automatic wait_fall();
        logic p;
        @(negedge clk);
        p = pwm_out;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (p && !pwm_out) return;
            p = pwm_out;
        end
    endtask

    task automatic cfg(input logic [31:0] dv, input logic [31:0] tp, input logic [31:0] cm);
        wr(2'd0, 32'd0);
        wr(2'd1, dv);
        wr(2'd3, tp);
        wr(2'd2, cm);
        wr(2'd0, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk(d == 32'd0, "R9 ctrl reset", d, 0);
        rd(2'd1, d); chk(d == 32'h10, "R9 div reset", d, 32'h10);
        rd(2'd2, d); chk(d == 32'd0, "R9 cmp reset", d, 0);
        rd(2'd3, d); chk(d == 32'hFFFF, "R9 top reset", d, 32'hFFFF);
        chk(pwm_out == 1'b0, "R9 pin low", pwm_out, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(2'd2, 32'hABCD0002); rd(2'd2, d); chk(d == 32'h2, "R8 cmp width", d, 2);
        wr(2'd3, 32'h12340007); rd(2'd3, d); chk(d == 32'h7, "R8 top width", d, 7);
        wr(2'd1, 32'hFFFF3018); rd(2'd1, d); chk(d == 32'h018, "R8 div width", d, 32'h18);
        wr(2'd0, 32'hFFFFFFFE); rd(2'd0, d); chk(d == 32'h0, "R8 ctrl width", d, 0);
    endtask

    task automatic t_duty();
        int hi, rs;
        cfg(32'h10, 32'd4, 32'd2);
        idle(20); measure(50, hi, rs); chk(hi == 20, "R6 duty 2/5", hi, 20);
        wr(2'd2, 32'd4); idle(20); measure(50, hi, rs); chk(hi == 40, "R6 cmp equal top", hi, 40);
        wr(2'd2, 32'd0); idle(20); measure(50, hi, rs); chk(hi == 0, "R6 cmp zero low", hi, 0);
        wr(2'd2, 32'd5); idle(20); measure(50, hi, rs); chk(hi == 50, "R6 cmp above top high", hi, 50);
        cfg(32'h10, 32'd9, 32'd3);
        idle(20); measure(100, hi, rs);
        chk(hi == 30, "R5 period duty", hi, 30);
        chk(rs == 10, "R5 period rises", rs, 10);
    endtask

    task automatic t_divider();
        int hi, rs;
        cfg(32'h30, 32'd4, 32'd1);
        idle(40); measure(150, hi, rs);
        chk(rs == 10, "R2 divide by 3 rises", rs, 10);
        chk(hi == 30, "R2 divide by 3 high", hi, 30);
        cfg(32'h18, 32'd2, 32'd1);
        idle(20); measure(90, hi, rs);
        chk(rs == 20, "R4 divide by 1.5 rises", rs, 20);
        chk(hi == 30, "R4 divide by 1.5 high", hi, 30);
        cfg(32'h05, 32'd3, 32'd1);
        idle(10); measure(40, hi, rs);
        chk(rs == 10, "R3 sub-one divider rises", rs, 10);
        cfg(32'h00, 32'd1, 32'd1);
        idle(600); measure(1024, hi, rs);
        chk(rs == 2, "R3 zero divider rises", rs, 2);
        chk(hi == 512, "R3 zero divider high", hi, 512);
    endtask

    task automatic t_shadow();
        int hi, rs;
        cfg(32'h10, 32'd99, 32'd50);
        idle(150);
        wait_fall();
        wr(2'd2, 32'd80);
        measure(40, hi, rs);
        chk(hi == 0, "R7 no mid-period change", hi, 0);
        idle(120);
        measure(200, hi, rs);
        chk(hi == 160, "R7 new compare after wrap", hi, 160);
    endtask

    task automatic t_hold();
        int hi, rs;
        cfg(32'h10, 32'd99, 32'd50);
        idle(150);
        wait_fall();
        idle(10);
        wr(2'd0, 32'd0);
        idle(3);
        measure(200, hi, rs);
        chk(hi == 0, "R1 disabled pin low", hi, 0);
        wr(2'd0, 32'd1);
        measure(25, hi, rs);
        chk(hi == 0, "R1 count resumes from held value", hi, 0);
    endtask

    task automatic t_top_lower();
        int hi, rs;
        cfg(32'h10, 32'd199, 32'd100);
        idle(250);
        wait_fall();
        idle(50);
        wr(2'd2, 32'd5);
        wr(2'd3, 32'd20);
        idle(50);
        measure(210, hi, rs);
        chk(hi == 50, "R5 top lowered below count", hi, 50);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_regs();
        t_duty();
        t_divider();
        t_shadow();
        t_hold();
        t_top_lower();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule